// File: doc/BRIEF.md
# Dual-path branch target prefetcher

This block is the instruction fetch front end of a pipelined core. It keeps two small prefetch queues behind one instruction memory read port. In normal running one queue, the primary, holds the sequential stream and feeds decode through a valid/ready handshake. When decode reports a conditional branch together with its target, the other queue starts filling from the target address at once. The primary keeps prefetching the fall-through path, and the two share the memory port in alternation.

While the branch is open, nothing is handed to decode. When the branch resolves, the surviving queue drives decode from the next cycle. On a taken branch the target queue becomes the primary and the old sequential queue is emptied. On a not-taken branch the target queue is emptied. The memory returns responses in request order. Every request carries a one-bit queue tag, so a response for an emptied queue is discarded when it arrives. Only one branch can be open at a time, and decode is held off a second branch until the first one resolves.

Top module: `dual_path_prefetch`

## Requirements
- R1: While reset is held, out_valid is 0 and br_ready is 1, and the port requests address RESET_VEC. Reset leaves both queues empty.
- R2: With no branch open, decode receives words at consecutive addresses (each +1) starting from RESET_VEC. Each out_data is the word memory returned for out_addr.
- R3: A queue never has more than QDEPTH (4) words held plus requested, and throttles its own requests at that limit. While a branch is open, exactly QDEPTH target words are requested once memory is idle.
- R4: Once a branch is accepted, the first target request is issued within two cycles. Sequential prefetching continues alongside.
- R5: When both queues can request in consecutive request cycles, grants alternate between them.
- R6: While a branch is open, br_ready is 0, a further br_valid is ignored and out_valid is 0.
- R7: On a not-taken resolution, out_valid is 1 in the next cycle if the sequential queue holds a word. Delivery then resumes at the address after the last word handed out before the branch.
- R8: On a taken resolution, the next cycle presents the target word when it is already buffered. The target address is read from memory only once per branch.
- R9: After a taken resolution, delivery continues at target, target+1, and so on, beyond the buffered words. Fetching resumes after the last target word requested.
- R10: Responses that were in flight for an emptied queue are dropped and are never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | AW | Word address of the request |
| mem_rsp_valid | input | 1 | In-order read data valid |
| mem_rsp_data | input | DW | Read data |
| br_valid | input | 1 | Decode reports a conditional branch |
| br_ready | output | 1 | Branch can be accepted (low stalls decode) |
| br_target | input | AW | Target word address of the branch |
| rs_valid | input | 1 | Open branch resolves this cycle |
| rs_taken | input | 1 | Resolution outcome, 1 = taken |
| out_valid | output | 1 | Instruction word available to decode |
| out_ready | input | 1 | Decode takes the word |
| out_data | output | DW | Instruction word |
| out_addr | output | AW | Word address of out_data |

## Verification
The hardest case to reach is a response that arrives for a queue that has just been emptied. It needs several reads in flight at the exact cycle the branch resolves. A constrained-random phase makes memory stall at random, and decode throttles its ready at random. Branches open at random times and resolve after 1 to 12 cycles with random outcomes, so resolutions often land while requests are still outstanding. Directed passes with memory always ready pin down the cycle timing of both outcomes and the single read of the target.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
   // identifies one of the two physical prefetch queues
   typedef logic qsel_t;

   function automatic qsel_t other_q(input qsel_t q);
      return ~q;
   endfunction
endpackage

// File: rtl/dpf_queue.sv
module dpf_queue #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int DEPTH = 4,
   parameter logic [AW-1:0] RESET_ADDR = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic          flush,
   input  logic          req_take,
   input  logic          rsp_done,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head_data,
   output logic [AW-1:0] head_addr,
   output logic          empty,
   output logic          space,
   output logic [AW-1:0] fetch_addr,
   output logic [$clog2(DEPTH+1)-1:0] inflight
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);
   localparam logic [CW:0] LIMIT = (CW+1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
      $error("dpf_queue: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] data_q [DEPTH];
   logic [AW-1:0] addr_q [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count;
   logic [CW-1:0] inflight_q;
   logic [AW-1:0] fetch_q, push_addr_q;

   logic clear, do_push, do_pop;
   assign clear   = flush | load;
   assign do_push = push & ~clear;
   assign do_pop  = pop & ~clear;

   always_ff @(posedge clk) begin
      if (do_push) begin
         data_q[wr_ptr] <= push_data;
         addr_q[wr_ptr] <= push_addr_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr      <= '0;
         wr_ptr      <= '0;
         count       <= '0;
         inflight_q  <= '0;
         fetch_q     <= RESET_ADDR;
         push_addr_q <= RESET_ADDR;
      end else begin
         inflight_q <= inflight_q + CW'(req_take) - CW'(rsp_done);
         if (load) begin
            fetch_q     <= load_addr;
            push_addr_q <= load_addr;
         end else begin
            if (req_take) fetch_q <= fetch_q + 1'b1;
            if (do_push)  push_addr_q <= push_addr_q + 1'b1;
         end
         if (clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
         end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
         end
      end
   end

   assign head_data  = data_q[rd_ptr];
   assign head_addr  = addr_q[rd_ptr];
   assign empty      = (count == '0);
   assign space      = ({1'b0, count} + {1'b0, inflight_q}) < LIMIT;
   assign fetch_addr = fetch_q;
   assign inflight   = inflight_q;

   // R3: a word is only written when a slot is free
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
      (do_push && !do_pop) |-> (count < CW'(DEPTH)));

   // R3: held plus requested words stay within the queue depth
   a_r3_credit_bound: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, count} + {1'b0, inflight_q}) <= LIMIT);

   // R10: every response for this queue matches an earlier request
   a_r10_rsp_matched: assert property (@(posedge clk) disable iff (rst)
      rsp_done |-> (inflight_q != '0));
endmodule

// File: rtl/dpf_tagq.sv
module dpf_tagq #(
   parameter int DEPTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic push,
   input  logic tag_in,
   input  logic pop,
   output logic tag_out,
   output logic empty,
   output logic full
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
      $error("dpf_tagq: DEPTH must be a power of two of at least 2");
   end

   logic          tags [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count;

   always_ff @(posedge clk) begin
      if (push) tags[wr_ptr] <= tag_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign tag_out = tags[rd_ptr];
   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));

   // R10: the memory never returns more words than were requested
   a_r10_rsp_has_tag: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);

   // R3: queue credits keep the tag store from overflowing
   a_r3_tag_room: assert property (@(posedge clk) disable iff (rst)
      push |-> (!full || pop));
endmodule

// File: rtl/dpf_rr.sv
module dpf_rr (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] elig,
   input  logic       fire,
   output logic       grant,
   output logic       any
);
   logic last;

   assign any   = |elig;
   assign grant = (elig == 2'b11) ? ~last : elig[1];

   always_ff @(posedge clk) begin
      if (rst)       last <= 1'b1;
      else if (fire) last <= grant;
   end

   // R5: back-to-back grants with both queues eligible alternate
   a_r5_alternate: assert property (@(posedge clk) disable iff (rst)
      (fire && elig == 2'b11 && $past(fire) && !$past(rst)) |-> (grant != $past(grant)));
endmodule

// File: rtl/dual_path_prefetch.sv
module dual_path_prefetch #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int QDEPTH = 4,
   parameter logic [AW-1:0] RESET_VEC = 16'h0100
) (
   input  logic          clk,
   input  logic          rst,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data,
   input  logic          br_valid,
   output logic          br_ready,
   input  logic [AW-1:0] br_target,
   input  logic          rs_valid,
   input  logic          rs_taken,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data,
   output logic [AW-1:0] out_addr
);
   import dpf_pkg::*;

   localparam int CW = $clog2(QDEPTH+1);
   localparam int TAGS = 2 * QDEPTH;

   if (AW < 4) begin : g_bad_aw
      $error("dual_path_prefetch: AW must be at least 4");
   end

   qsel_t         prim, sec;
   logic          br_pend;
   logic [AW-1:0] br_target_q;

   logic          accept, resolve, mem_fire;
   logic [1:0]    elig, req_take, rsp_done, push, pop, load, flush;
   logic          grant, any_elig;
   logic          tag_head, tag_empty, tag_full;

   logic [DW-1:0] head_data_a [2];
   logic [AW-1:0] head_addr_a [2];
   logic [AW-1:0] fetch_a [2];
   logic [CW-1:0] inflight_a [2];
   logic [1:0]    empty_a, space_a;

   assign sec      = other_q(prim);
   assign accept   = br_valid && br_ready;
   assign resolve  = rs_valid && br_pend;
   assign mem_fire = mem_req_valid && mem_req_ready;

   for (genvar i = 0; i < 2; i++) begin : g_q
      localparam logic [AW-1:0] START = (i == 0) ? RESET_VEC : '0;
      logic is_prim;
      assign is_prim     = (prim == qsel_t'(i));
      assign elig[i]     = space_a[i] && (is_prim || br_pend);
      assign load[i]     = accept && !is_prim;
      assign flush[i]    = resolve && (rs_taken ? is_prim : !is_prim);
      assign req_take[i] = mem_fire && (grant == qsel_t'(i));
      assign rsp_done[i] = mem_rsp_valid && (tag_head == qsel_t'(i));
      assign push[i]     = rsp_done[i] && (is_prim || br_pend);
      assign pop[i]      = is_prim && out_valid && out_ready;

      dpf_queue #(
         .AW(AW), .DW(DW), .DEPTH(QDEPTH), .RESET_ADDR(START)
      ) u_q (
         .clk(clk), .rst(rst),
         .load(load[i]), .load_addr(br_target),
         .flush(flush[i]),
         .req_take(req_take[i]), .rsp_done(rsp_done[i]),
         .push(push[i]), .push_data(mem_rsp_data),
         .pop(pop[i]),
         .head_data(head_data_a[i]), .head_addr(head_addr_a[i]),
         .empty(empty_a[i]), .space(space_a[i]),
         .fetch_addr(fetch_a[i]), .inflight(inflight_a[i])
      );
   end

   dpf_rr u_rr (
      .clk(clk), .rst(rst), .elig(elig), .fire(mem_fire),
      .grant(grant), .any(any_elig)
   );

   dpf_tagq #(.DEPTH(TAGS)) u_tags (
      .clk(clk), .rst(rst),
      .push(mem_fire), .tag_in(grant),
      .pop(mem_rsp_valid), .tag_out(tag_head),
      .empty(tag_empty), .full(tag_full)
   );

   assign mem_req_valid = any_elig && !tag_full;
   assign mem_req_addr  = fetch_a[grant];

   assign br_ready  = !br_pend && (inflight_a[sec] == '0);
   assign out_valid = !br_pend && !empty_a[prim];
   assign out_data  = head_data_a[prim];
   assign out_addr  = head_addr_a[prim];

   always_ff @(posedge clk) begin
      if (rst) begin
         prim        <= 1'b0;
         br_pend     <= 1'b0;
         br_target_q <= '0;
      end else begin
         if (accept) begin
            br_pend     <= 1'b1;
            br_target_q <= br_target;
         end else if (resolve) begin
            br_pend <= 1'b0;
            if (rs_taken) prim <= sec;
         end
      end
   end

   // R6: a branch offered while one is open leaves the held target alone
   a_r6_second_ignored: assert property (@(posedge clk) disable iff (rst)
      (br_pend && br_valid && !resolve) |=> (br_target_q == $past(br_target_q)));

   // R7: a not-taken outcome keeps the same queue feeding decode
   a_r7_keep_stream: assert property (@(posedge clk) disable iff (rst)
      (resolve && !rs_taken) |=> (prim == $past(prim)));

   // R8: once the target word has been requested it is not read again after a taken outcome
   a_r8_no_refetch: assert property (@(posedge clk) disable iff (rst)
      $past(resolve && rs_taken && (fetch_a[sec] != br_target_q))
      |-> !(mem_fire && mem_req_addr == $past(br_target_q)));

   // R10: nothing is delivered while the tag store says no word came back
   a_r10_no_phantom: assert property (@(posedge clk) disable iff (rst)
      (mem_rsp_valid && tag_empty) |-> 1'b0);
endmodule

// File: tb/dual_path_prefetch_tb.sv
module dual_path_prefetch_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int QD = 4;
   localparam logic [AW-1:0] RV = 16'h0100;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst;
   logic          mem_req_valid, mem_req_ready;
   logic [AW-1:0] mem_req_addr;
   logic          mem_rsp_valid;
   logic [DW-1:0] mem_rsp_data;
   logic          br_valid, br_ready;
   logic [AW-1:0] br_target;
   logic          rs_valid, rs_taken;
   logic          out_valid, out_ready;
   logic [DW-1:0] out_data;
   logic [AW-1:0] out_addr;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   bit            rnd_mem = 1'b0;
   bit            rnd_out = 1'b0;
   logic [AW-1:0] exp_addr;
   int            deliv = 0;
   logic [AW-1:0] watch_addr = 16'hFFFF;
   int            watch_hits = 0;
   int            range_hits = 0;
   int            first_hit = -1;

   logic          pv [LAT];
   logic [AW-1:0] pa [LAT];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dual_path_prefetch #(.AW(AW), .DW(DW), .QDEPTH(QD), .RESET_VEC(RV)) u_dut (
      .clk(clk), .rst(rst),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .br_valid(br_valid), .br_ready(br_ready), .br_target(br_target),
      .rs_valid(rs_valid), .rs_taken(rs_taken),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_addr(out_addr)
   );

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return {a ^ 16'hA5C3, a};
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // in-order memory with fixed latency, optional random stalls
   always @(negedge clk) begin
      if (rst) begin
         mem_req_ready = 1'b0;
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = '0;
         for (int k = 0; k < LAT; k++) begin
            pv[k] = 1'b0;
            pa[k] = '0;
         end
      end else begin
         mem_req_ready = rnd_mem ? ($urandom % 4 != 0) : 1'b1;
         mem_rsp_valid = pv[LAT-1];
         mem_rsp_data  = word_of(pa[LAT-1]);
         for (int k = LAT-1; k > 0; k--) begin
            pv[k] = pv[k-1];
            pa[k] = pa[k-1];
         end
         pv[0] = mem_req_valid && mem_req_ready;
         pa[0] = mem_req_addr;
         if (pv[0]) begin
            if (mem_req_addr == watch_addr) begin
               watch_hits++;
               if (first_hit < 0) first_hit = cyc;
            end
            if (mem_req_addr >= watch_addr && mem_req_addr < watch_addr + 16'd16)
               range_hits++;
         end
      end
   end

   task automatic tick();
      @(negedge clk);
      out_ready = rnd_out ? ($urandom % 4 != 0) : 1'b1;
      if (out_valid && out_ready) begin
         check(out_addr == exp_addr, "R2 R10 delivery address", 32'(out_addr), 32'(exp_addr));
         check(out_data == word_of(out_addr), "R2 R10 delivery data", out_data, word_of(out_addr));
         exp_addr = exp_addr + 1'b1;
         deliv++;
      end
   endtask

   task automatic open_branch(input logic [AW-1:0] tgt, output int acc_cyc);
      tick();
      br_valid   = 1'b1;
      br_target  = tgt;
      watch_addr = tgt;
      watch_hits = 0;
      range_hits = 0;
      first_hit  = -1;
      acc_cyc    = cyc;
      tick();
      br_valid = 1'b0;
      check(br_ready == 1'b0, "R6 br_ready low while open", 32'(br_ready), 32'd0);
      check(out_valid == 1'b0, "R6 no delivery while open", 32'(out_valid), 32'd0);
      br_valid  = 1'b1;
      br_target = 16'h9999;
      tick();
      br_valid = 1'b0;
      repeat (18) tick();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
   end

   initial begin : main
      int acc;
      int d0;
      logic [AW-1:0] e;
      bit pend;
      int wait_n;
      bit chk_after;
      logic [AW-1:0] tgt;

      void'($urandom(24680));
      rst = 1'b1;
      br_valid = 1'b0; br_target = '0;
      rs_valid = 1'b0; rs_taken = 1'b0;
      out_ready = 1'b0;
      exp_addr = RV;
      repeat (5) @(negedge clk);
      // R1: reset state, before the first active edge after release
      check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
      check(br_ready == 1'b1, "R1 br_ready after reset", 32'(br_ready), 32'd1);
      check(mem_req_valid == 1'b1, "R1 first request valid", 32'(mem_req_valid), 32'd1);
      check(mem_req_addr == RV, "R1 first request address", 32'(mem_req_addr), 32'(RV));
      rst = 1'b0;

      // R2: plain sequential stream
      repeat (40) tick();
      check(deliv >= 20, "R2 sequential progress", deliv, 20);

      // taken branch with the target fully buffered
      open_branch(16'h8000, acc);
      check(range_hits == QD, "R3 target requests capped at depth", range_hits, QD);
      rs_valid = 1'b1; rs_taken = 1'b1;
      exp_addr = 16'h8000;
      e = exp_addr;
      d0 = deliv;
      tick();
      rs_valid = 1'b0;
      check(out_valid == 1'b1, "R8 target ready next cycle", 32'(out_valid), 32'd1);
      check(out_addr == e, "R8 first word is target", 32'(out_addr), 32'(e));
      repeat (25) tick();
      check(watch_hits == 1, "R8 single read of target", watch_hits, 1);
      check(first_hit - acc >= 1 && first_hit - acc <= 2, "R4 R5 target fetch starts",
            first_hit - acc, 2);
      check(deliv - d0 >= 10, "R9 fetch continues after target words", deliv - d0, 10);

      // not-taken branch: sequential words issue at once
      open_branch(16'h4000, acc);
      rs_valid = 1'b1; rs_taken = 1'b0;
      e = exp_addr;
      tick();
      rs_valid = 1'b0;
      check(out_valid == 1'b1, "R7 sequential ready next cycle", 32'(out_valid), 32'd1);
      check(out_addr == e, "R7 resumes after last delivered", 32'(out_addr), 32'(e));
      repeat (30) tick();

      // constrained random: stalls on both sides, random branch timing and outcome
      rnd_mem = 1'b1;
      rnd_out = 1'b1;
      pend = 1'b0; wait_n = 0; chk_after = 1'b0; tgt = '0;
      d0 = deliv;
      for (int n = 0; n < 4000; n++) begin
         tick();
         br_valid = 1'b0;
         rs_valid = 1'b0;
         if (!pend) begin
            if (br_ready && ($urandom % 12 == 0)) begin
               tgt       = 16'($urandom);
               br_valid  = 1'b1;
               br_target = tgt;
               pend      = 1'b1;
               wait_n    = 1 + ($urandom % 12);
               chk_after = 1'b1;
            end
         end else begin
            if (chk_after) begin
               check(br_ready == 1'b0, "R6 stall on open branch", 32'(br_ready), 32'd0);
               check(out_valid == 1'b0, "R6 hold output on open branch", 32'(out_valid), 32'd0);
               chk_after = 1'b0;
            end
            wait_n--;
            if (wait_n <= 0) begin
               rs_valid = 1'b1;
               rs_taken = ($urandom % 2) == 1;
               if (rs_taken) exp_addr = tgt;
               pend = 1'b0;
            end else if ($urandom % 3 == 0) begin
               br_valid  = 1'b1;
               br_target = 16'($urandom);
            end
         end
      end
      br_valid = 1'b0;
      rs_valid = 1'b0;
      rnd_mem = 1'b0;
      rnd_out = 1'b0;
      repeat (50) tick();
      check(deliv - d0 >= 200, "R2 R10 random phase progress", deliv - d0, 200);

      summary();
      $finish;
   end
endmodule